// File: doc/BRIEF.md
# Vector Lane Multiplier with Accumulator

This block multiplies two 256-bit vectors lane by lane, treating them as either sixteen 16-bit lanes or eight 32-bit lanes. Within each pair of adjacent lanes only one lane takes part: the even lane or the odd lane, picked per operation. The second factor comes either from the matching lane of the second operand or from one lane of one of two lane registers, and that lane is used for every product. Every product is unsigned and twice the lane width. The result keeps the lower or the upper half of each product in the lane it came from.

The same products can also be added into an accumulator that is split across two 256-bit outputs. For each lane pair, the low output holds the lower half of a sum that is four lanes wide and the high output holds the upper half. A clear option zeroes that sum before the add. The arithmetic runs on one array of 16×16 multipliers. A 16-bit operation completes in one cycle. A 32-bit operation builds each 32×32 product from four partial products computed over two cycles. Modular reduction is done outside this block.

Top module: `vmul_top`

## Requirements
- R1: With `fmt32`=0, lane i occupies bits [16i+15:16i]. For each pair k (0..7) the selected lane is s=2k+`odd`. The block forms the 32-bit unsigned product `opa` lane s × B, where B is `opb` lane s. `res` lane s then holds bits [15:0] of that product when `hi`=0, or bits [31:16] when `hi`=1.
- R2: With `fmt32`=1, lane i occupies bits [32i+31:32i]. For each pair j (0..3) the selected lane is s=2j+`odd`. The block forms the 64-bit unsigned product of `opa` lane s and B. `res` lane s holds bits [31:0] of that product when `hi`=0, or bits [63:32] when `hi`=1.
- R3: In every lane pair, the lane that is not selected (index s xor 1) reads zero in `res`.
- R4: With `bcast`=1, B for every pair is one lane of the lane register chosen by `lsel` (0 picks `lreg0`, 1 picks `lreg1`). That lane is `lidx` in 16-bit format, or `lidx[2:0]` in 32-bit format, where `lidx[3]` is ignored.
- R5: With `acc_en`=1, each pair keeps a 4×lane-width unsigned sum, and the zero-extended product of that pair is added to it. In 16-bit format, pair k is {`acc_hi`[32k+31:32k], `acc_lo`[32k+31:32k]}. In 32-bit format, pair j is {`acc_hi`[64j+63:64j], `acc_lo`[64j+63:64j]}. The sum wraps modulo 2^(4×lane width).
- R6: With `acc_clr`=1, every sum is zeroed before the add. With `acc_clr`=1 and `acc_en`=0, both accumulator outputs end at zero.
- R7: With both `acc_en`=0 and `acc_clr`=0, the accumulator outputs keep their values. The accumulator outputs change only in a cycle where `done` is high.
- R8: `start` is sampled on a rising edge. For a 16-bit operation, `done` is high for exactly the next cycle, and `res` and the accumulator outputs already show that operation. For a 32-bit operation, `done` stays low for the first cycle and is high for the second cycle.
- R9: A `start` given in the second cycle of a 32-bit operation is ignored. The running operation completes unchanged and no further `done` follows.
- R10: Reset (`rst_n`=0) drives `res`, `acc_lo`, `acc_hi` and `done` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the options and operands present this cycle |
| fmt32 | input | 1 | Lane format: 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| odd | input | 1 | 0 selects the even lane of each pair, 1 the odd lane |
| bcast | input | 1 | Take the second factor from a lane register lane |
| lsel | input | 1 | Lane register select (0: lreg0, 1: lreg1) |
| lidx | input | 4 | Lane index inside the chosen lane register |
| hi | input | 1 | 0 returns the lower half of each product, 1 the upper half |
| acc_en | input | 1 | Add the products into the accumulator |
| acc_clr | input | 1 | Zero the accumulator before the add |
| opa | input | 256 | First operand vector |
| opb | input | 256 | Second operand vector |
| lreg0 | input | 256 | Lane register 0 |
| lreg1 | input | 256 | Lane register 1 |
| res | output | 256 | Product halves in the selected lanes |
| acc_lo | output | 256 | Lower halves of the per-pair sums |
| acc_hi | output | 256 | Upper halves of the per-pair sums |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
A 32-bit operation carries state from its first cycle to its second: the partial sums, the captured operands and the captured options. If any of these is wrong, the fault shows in `res` and in the accumulator outputs in the very cycle that `done` rises, so each operation is checked in that cycle. Accumulator faults can stay hidden in the upper half until a carry reaches it. For that reason the sequence runs several accumulations in a row, including all-ones operands. A fault in the phase tracking shows as `done` arriving one cycle early or late, or as an extra `done` after a `start` that should have been ignored. The bench samples `done` in each of these cycles.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

   // Options that must survive into the second cycle of a 32-bit operation
   typedef struct packed {
      logic odd;
      logic hi;
      logic acc_en;
      logic acc_clr;
   } vmul_op_t;

endpackage

// File: rtl/vmul_opsel.sv
// Picks the active lane of every pair and the second factor for it,
// in both lane formats at once.
module vmul_opsel #(
   parameter int unsigned VLEN = 256,
   localparam int unsigned NP16 = VLEN / 32,
   localparam int unsigned NP32 = VLEN / 64,
   localparam int unsigned IDXW = $clog2(VLEN / 16)
) (
   input  logic [VLEN-1:0]            opa,
   input  logic [VLEN-1:0]            opb,
   input  logic [VLEN-1:0]            lreg0,
   input  logic [VLEN-1:0]            lreg1,
   input  logic                       bcast,
   input  logic                       lsel,
   input  logic [IDXW-1:0]            lidx,
   input  logic                       odd,
   output logic [NP16-1:0][15:0]      a16,
   output logic [NP16-1:0][15:0]      b16,
   output logic [NP32-1:0][31:0]      a32,
   output logic [NP32-1:0][31:0]      b32
);

   logic [VLEN-1:0] lr;
   logic [15:0]     bc16;
   logic [31:0]     bc32;

   always_comb begin
      lr   = lsel ? lreg1 : lreg0;
      bc16 = lr[int'(lidx) * 16 +: 16];
      bc32 = lr[int'(lidx[IDXW-2:0]) * 32 +: 32];
   end

   for (genvar k = 0; k < NP16; k++) begin : g_p16
      assign a16[k] = odd ? opa[32*k+16 +: 16] : opa[32*k +: 16];
      assign b16[k] = bcast ? bc16 : (odd ? opb[32*k+16 +: 16] : opb[32*k +: 16]);
   end

   for (genvar j = 0; j < NP32; j++) begin : g_p32
      assign a32[j] = odd ? opa[64*j+32 +: 32] : opa[64*j +: 32];
      assign b32[j] = bcast ? bc32 : (odd ? opb[64*j+32 +: 32] : opb[64*j +: 32]);
   end

endmodule

// File: rtl/vmul_array.sv
// Shared array of unsigned 16x16 multipliers.
module vmul_array #(
   parameter int unsigned NMUL = 8
) (
   input  logic [NMUL-1:0][15:0] x,
   input  logic [NMUL-1:0][15:0] y,
   output logic [NMUL-1:0][31:0] p
);

   if (NMUL < 2 || (NMUL % 2) != 0) begin : g_bad
      $error("vmul_array: NMUL must be even and at least 2");
   end

   for (genvar k = 0; k < NMUL; k++) begin : g_mul
      assign p[k] = x[k] * y[k];
   end

endmodule

// File: rtl/vmul_lane_unit.sv
// Per-format back end: places product halves into result lanes and
// computes the next accumulator value for every lane pair.
module vmul_lane_unit #(
   parameter int unsigned VLEN = 256,
   parameter int unsigned LW   = 16,
   localparam int unsigned PW  = 2 * LW,
   localparam int unsigned NS  = VLEN / PW
) (
   input  logic [NS-1:0][PW-1:0] prod,
   input  logic [VLEN-1:0]       acc_lo,
   input  logic [VLEN-1:0]       acc_hi,
   input  logic                  odd,
   input  logic                  hi,
   input  logic                  clr,
   input  logic                  add,
   output logic [VLEN-1:0]       res,
   output logic [VLEN-1:0]       nlo,
   output logic [VLEN-1:0]       nhi
);

   if (LW != 16 && LW != 32) begin : g_bad
      $error("vmul_lane_unit: LW must be 16 or 32");
   end

   for (genvar s = 0; s < NS; s++) begin : g_slot
      logic [LW-1:0]   half;
      logic [2*PW-1:0] base;
      logic [2*PW-1:0] sum;

      assign half = hi ? prod[s][PW-1:LW] : prod[s][LW-1:0];
      assign res[PW*s +: PW] = odd ? {half, {LW{1'b0}}} : {{LW{1'b0}}, half};

      assign base = clr ? '0 : {acc_hi[PW*s +: PW], acc_lo[PW*s +: PW]};
      assign sum  = base + (add ? {{PW{1'b0}}, prod[s]} : '0);
      assign nlo[PW*s +: PW] = sum[PW-1:0];
      assign nhi[PW*s +: PW] = sum[2*PW-1:PW];
   end

endmodule

// File: rtl/vmul_top.sv
module vmul_top
   import vmul_pkg::*;
#(
   parameter int unsigned VLEN = 256,
   localparam int unsigned NP16 = VLEN / 32,
   localparam int unsigned NP32 = VLEN / 64,
   localparam int unsigned NMUL = NP16,
   localparam int unsigned IDXW = $clog2(VLEN / 16)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            fmt32,
   input  logic            odd,
   input  logic            bcast,
   input  logic            lsel,
   input  logic [IDXW-1:0] lidx,
   input  logic            hi,
   input  logic            acc_en,
   input  logic            acc_clr,
   input  logic [VLEN-1:0] opa,
   input  logic [VLEN-1:0] opb,
   input  logic [VLEN-1:0] lreg0,
   input  logic [VLEN-1:0] lreg1,
   output logic [VLEN-1:0] res,
   output logic [VLEN-1:0] acc_lo,
   output logic [VLEN-1:0] acc_hi,
   output logic            done
);

   if (VLEN < 64 || (VLEN % 64) != 0) begin : g_bad_vlen
      $error("vmul_top: VLEN must be a multiple of 64");
   end
   if (NMUL != 2 * NP32) begin : g_bad_arr
      $error("vmul_top: array size must cover two partial products per 32-bit pair");
   end

   // ---------------- operand selection ----------------
   logic [NP16-1:0][15:0] a16, b16;
   logic [NP32-1:0][31:0] a32, b32;

   vmul_opsel #(.VLEN(VLEN)) u_sel (
      .opa(opa), .opb(opb), .lreg0(lreg0), .lreg1(lreg1),
      .bcast(bcast), .lsel(lsel), .lidx(lidx), .odd(odd),
      .a16(a16), .b16(b16), .a32(a32), .b32(b32)
   );

   // ---------------- sequencing state ----------------
   logic                  phase1;          // second cycle of a 32-bit op
   vmul_op_t              op_in, op_q, cur_op;
   logic [NP32-1:0][31:0] a32_q, b32_q;
   logic [NP32-1:0][47:0] t_q, t_n;
   logic                  accept, fin16, fin32;

   assign op_in  = '{odd: odd, hi: hi, acc_en: acc_en, acc_clr: acc_clr};
   assign cur_op = phase1 ? op_q : op_in;
   assign accept = start & ~phase1;
   assign fin16  = accept & ~fmt32;
   assign fin32  = phase1;

   // ---------------- shared multiplier array ----------------
   logic [NMUL-1:0][15:0] mx, my;
   logic [NMUL-1:0][31:0] mp;

   always_comb begin
      mx = a16;
      my = b16;
      for (int j = 0; j < NP32; j++) begin
         if (phase1) begin
            mx[2*j]   = a32_q[j][15:0];
            my[2*j]   = b32_q[j][31:16];
            mx[2*j+1] = a32_q[j][31:16];
            my[2*j+1] = b32_q[j][31:16];
         end else if (fmt32) begin
            mx[2*j]   = a32[j][15:0];
            my[2*j]   = b32[j][15:0];
            mx[2*j+1] = a32[j][31:16];
            my[2*j+1] = b32[j][15:0];
         end
      end
   end

   vmul_array #(.NMUL(NMUL)) u_arr (.x(mx), .y(my), .p(mp));

   // partial sums (first cycle) and full 64-bit products (second cycle)
   logic [NP32-1:0][63:0] p64;
   always_comb begin
      for (int j = 0; j < NP32; j++) begin
         t_n[j] = {16'b0, mp[2*j]} + {mp[2*j+1], 16'b0};
         p64[j] = {16'b0, t_q[j]} + {16'b0, mp[2*j], 16'b0} + {mp[2*j+1], 32'b0};
      end
   end

   // ---------------- per-format back ends ----------------
   logic [VLEN-1:0] res16, nlo16, nhi16, res32, nlo32, nhi32;

   vmul_lane_unit #(.VLEN(VLEN), .LW(16)) u_l16 (
      .prod(mp), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .odd(cur_op.odd), .hi(cur_op.hi), .clr(cur_op.acc_clr), .add(cur_op.acc_en),
      .res(res16), .nlo(nlo16), .nhi(nhi16)
   );

   vmul_lane_unit #(.VLEN(VLEN), .LW(32)) u_l32 (
      .prod(p64), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .odd(cur_op.odd), .hi(cur_op.hi), .clr(cur_op.acc_clr), .add(cur_op.acc_en),
      .res(res32), .nlo(nlo32), .nhi(nhi32)
   );

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase1 <= 1'b0;
         op_q   <= '0;
         a32_q  <= '0;
         b32_q  <= '0;
         t_q    <= '0;
         res    <= '0;
         acc_lo <= '0;
         acc_hi <= '0;
         done   <= 1'b0;
      end else begin
         if (accept && fmt32) begin
            phase1 <= 1'b1;
            op_q   <= op_in;
            a32_q  <= a32;
            b32_q  <= b32;
            t_q    <= t_n;
         end else if (phase1) begin
            phase1 <= 1'b0;
         end
         done <= fin16 | fin32;
         if (fin16) begin
            res <= res16;
            if (op_in.acc_en || op_in.acc_clr) begin
               acc_lo <= nlo16;
               acc_hi <= nhi16;
            end
         end else if (fin32) begin
            res <= res32;
            if (op_q.acc_en || op_q.acc_clr) begin
               acc_lo <= nlo32;
               acc_hi <= nhi32;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   a_r8_done16: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !phase1 && !fmt32) |=> done);

   a_r8_done32: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !phase1 && fmt32) |=> (!done ##1 done));

   a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(acc_lo) && $stable(acc_hi)));

   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (phase1 && start) |=> !phase1);

   a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !phase1 && !fmt32 && acc_clr && !acc_en) |=> (acc_lo == '0 && acc_hi == '0));

endmodule

// File: tb/tb_vmul_top.sv
`timescale 1ns/1ps
module tb_vmul_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, fmt32 = 1'b0, odd = 1'b0, bcast = 1'b0, lsel = 1'b0;
   logic [3:0]   lidx = '0;
   logic         hi = 1'b0, acc_en = 1'b0, acc_clr = 1'b0;
   logic [255:0] opa = '0, opb = '0, lreg0 = '0, lreg1 = '0;
   logic [255:0] res, acc_lo, acc_hi;
   logic         done;

   int errors = 0;
   int checks = 0;

   logic [255:0] m_lo = '0, m_hi = '0;   // bench model of the accumulator

   always #10 clk = ~clk;                // 50 MHz

   vmul_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt32(fmt32), .odd(odd),
      .bcast(bcast), .lsel(lsel), .lidx(lidx), .hi(hi), .acc_en(acc_en),
      .acc_clr(acc_clr), .opa(opa), .opb(opb), .lreg0(lreg0), .lreg1(lreg1),
      .res(res), .acc_lo(acc_lo), .acc_hi(acc_hi), .done(done)
   );

   // {fmt32, odd, bcast, lsel, lidx[3:0], hi, acc_en, acc_clr, seed[4:0]}
   localparam logic [15:0] VEC [16] = '{
      16'h0001, 16'h4082, 16'h2503, 16'h7F84,
      16'h8005, 16'hC086, 16'hBB07, 16'h0068,
      16'h0049, 16'h000A, 16'h806B, 16'h804C,
      16'h00DF, 16'h80DF, 16'h002D, 16'hC04E
   };

   function automatic logic [255:0] gen(input int unsigned s);
      logic [255:0] v;
      int unsigned  x;
      x = s * 32'd2654435761 + 32'd1;
      for (int i = 0; i < 8; i++) begin
         x = x * 32'd1103515245 + 32'd12345;
         v[32*i +: 32] = x ^ (x >> 7);
      end
      return v;
   endfunction

   task automatic chk_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Expected result and accumulator update, written from R1..R6
   task automatic model(input logic f, o, b, l, input logic [3:0] ix,
                        input logic h, a, c,
                        input logic [255:0] va, vb, v0, v1,
                        output logic [255:0] er);
      logic [255:0] lr;
      lr = l ? v1 : v0;
      er = '0;
      if (!f) begin
         for (int k = 0; k < 8; k++) begin
            int          s;
            logic [15:0] x, y;
            logic [31:0] p;
            logic [63:0] sm;
            s  = 2*k + int'(o);
            x  = va[16*s +: 16];
            y  = b ? lr[16*int'(ix) +: 16] : vb[16*s +: 16];
            p  = x * y;
            er[16*s +: 16] = h ? p[31:16] : p[15:0];
            sm = c ? 64'd0 : {m_hi[32*k +: 32], m_lo[32*k +: 32]};
            if (a) sm = sm + {32'd0, p};
            if (a || c) begin
               m_lo[32*k +: 32] = sm[31:0];
               m_hi[32*k +: 32] = sm[63:32];
            end
         end
      end else begin
         for (int j = 0; j < 4; j++) begin
            int           s;
            logic [31:0]  x, y;
            logic [63:0]  p;
            logic [127:0] sm;
            s  = 2*j + int'(o);
            x  = va[32*s +: 32];
            y  = b ? lr[32*int'(ix[2:0]) +: 32] : vb[32*s +: 32];
            p  = x * y;
            er[32*s +: 32] = h ? p[63:32] : p[31:0];
            sm = c ? 128'd0 : {m_hi[64*j +: 64], m_lo[64*j +: 64]};
            if (a) sm = sm + {64'd0, p};
            if (a || c) begin
               m_lo[64*j +: 64] = sm[63:0];
               m_hi[64*j +: 64] = sm[127:64];
            end
         end
      end
   endtask

   task automatic drive(input logic [15:0] e, input logic [255:0] va, vb, v0, v1);
      fmt32 = e[15]; odd = e[14]; bcast = e[13]; lsel = e[12]; lidx = e[11:8];
      hi = e[7]; acc_en = e[6]; acc_clr = e[5];
      opa = va; opb = vb; lreg0 = v0; lreg1 = v1;
   endtask

   task automatic run_op(input logic [15:0] e);
      logic [255:0] va, vb, v0, v1, er;
      string        rq, aq;
      if (e[4:0] == 5'd31) begin
         va = '1; vb = '1; v0 = '1; v1 = '1;
      end else begin
         va = gen(4*e[4:0]); vb = gen(4*e[4:0] + 1);
         v0 = gen(4*e[4:0] + 2); v1 = gen(4*e[4:0] + 3);
      end
      model(e[15], e[14], e[13], e[12], e[11:8], e[7], e[6], e[5], va, vb, v0, v1, er);
      rq = e[13] ? "R4 broadcast" : (e[14] ? "R3 odd lanes" : (e[15] ? "R2 32-bit" : "R1 16-bit"));
      aq = e[5] ? "R6 clear" : (e[6] ? "R5 accumulate" : "R7 hold");
      @(negedge clk);
      drive(e, va, vb, v0, v1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (e[15]) begin
         chk_bit("R8 no done in first 32-bit cycle", done, 1'b0);
         @(negedge clk);
      end
      chk_bit("R8 done", done, 1'b1);
      chk_vec(rq, res, er);
      chk_vec({aq, " lo"}, acc_lo, m_lo);
      chk_vec({aq, " hi"}, acc_hi, m_hi);
   endtask

   initial begin
      #(20ns * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [255:0] er;
      logic [255:0] hold_lo, hold_hi;
      repeat (3) @(negedge clk);
      // R10: state while and just after reset
      chk_vec("R10 res", res, '0);
      chk_vec("R10 acc_lo", acc_lo, '0);
      chk_vec("R10 acc_hi", acc_hi, '0);
      chk_bit("R10 done", done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_bit("R10 done after release", done, 1'b0);

      foreach (VEC[i]) run_op(VEC[i]);

      // R8: done is a single pulse when no new start follows
      @(negedge clk);
      chk_bit("R8 pulse ends", done, 1'b0);

      // load a nonzero accumulator for the R9 test
      run_op(16'h8047);

      // R9: start in second 32-bit cycle is ignored
      hold_lo = m_lo; hold_hi = m_hi;
      begin
         logic [255:0] va, vb;
         va = gen(200); vb = gen(201);
         model(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, va, vb, '0, '0, er);
         @(negedge clk);
         drive(16'h8080, va, vb, '0, '0);
         start = 1'b1;
         @(negedge clk);
         chk_bit("R9 first cycle", done, 1'b0);
         drive(16'h4060, gen(300), gen(301), '0, '0);   // 16-bit clear+acc, must be dropped
         @(negedge clk);
         start = 1'b0;
         chk_bit("R9 done of running op", done, 1'b1);
         chk_vec("R9 result of running op", res, er);
         @(negedge clk);
         chk_bit("R9 no extra done", done, 1'b0);
         chk_vec("R9 acc_lo untouched", acc_lo, hold_lo);
         chk_vec("R9 acc_hi untouched", acc_hi, hold_hi);
      end

      // R10: reset in the middle of use clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_vec("R10 acc_lo mid-run", acc_lo, '0);
      chk_vec("R10 res mid-run", res, '0);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule